// File: doc/BRIEF.md
# Indexed Reorder Shape Binder

This block carries out one configuration command for indexed element reordering. It fills four shape records. Each record holds an index register number, an element count, an element-width code and two flags. It also binds each of five operand slots to one of those shapes through a 2-bit selector and an enable bit. The five slots are three source operands (A, B, C) and two destination operands (D0, D1). A persistence flag, set elsewhere, is kept beside the bindings.

A command is accepted on a `start_i` pulse. It can run in one of two ways. In broadcast mode (`mm_i`=0) everything is wiped first. Then every operand whose mask bit is set gets the next free shape, in rising bit order, at one shape write per cycle. In targeted mode (`mm_i`=1) the mask holds an operand code and a shape number, and only that one shape and that one binding change. `done_o` pulses once when the command has been fully applied.

Top module: `remap_index_seq`

## Requirements
- R1: After reset every shape record, selector, enable bit and the persistence flag read zero, and `busy_o` and `done_o` are low.
- R2: A broadcast command (`mm_i`=0) clears all four shapes, all selectors, all enable bits and the persistence flag in the cycle it is accepted.
- R3: In broadcast mode, mask bit k selects operand k (0=A, 1=B, 2=C, 3=D0, 4=D1). Set bits are served in rising order. Each one gets the next shape index, starting at 0 and counting modulo 4. Its enable bit is set and its selector `sel_o[2k+1:2k]` takes that index.
- R4: A broadcast mask of 5'b11111 binds both operand A and operand D1 to shape 0.
- R5: A targeted command (`mm_i`=1) uses `rmm_i[2:0]` as an operand code and `rmm_i[4:3]` as a shape number. Only that shape is written. Only that operand's enable bit and selector are set. Operand codes 5 to 7 bind nothing, but the shape is still written.
- R6: A targeted command leaves the persistence flag and every other shape and binding unchanged.
- R7: A written shape record occupies `shapes_o[18s+17:18s]` for shape s. Its bits [6:0] hold `{rs_i,2'b00}`, [12:7] hold `svd_i+1` (1 to 32), [14:13] hold `ew_i`, bit 15 holds `yx_i` and bit 16 holds `sk_i`.
- R8: Bit 17 of a written shape record (the one-dimensional mark) is the inverse of `yx_i`.
- R9: `done_o` is a one-cycle pulse. For a broadcast command with n set mask bits it is high in cycle n+1 after the accepting edge, with `busy_o` high during the n write cycles. For a targeted command, or an empty broadcast mask, it is high in cycle 1.
- R10: A `start_i` pulse that arrives while `busy_o` is high is ignored.
- R11: `pst_set_i` sets the persistence flag. A broadcast command accepted in the same cycle takes priority and clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Command strobe |
| mm_i | input | 1 | 0 broadcast, 1 targeted |
| rmm_i | input | 5 | Operand mask, or operand code plus shape number |
| rs_i | input | 5 | Index register number, upper five bits |
| svd_i | input | 5 | Element count minus one |
| ew_i | input | 2 | Element-width code |
| yx_i | input | 1 | Two-dimensional reorder flag |
| sk_i | input | 1 | Dimension skip flag |
| pst_set_i | input | 1 | Sets the persistence flag |
| busy_o | output | 1 | Broadcast write sequence running |
| done_o | output | 1 | Command complete pulse |
| shapes_o | output | 72 | Four 18-bit shape records |
| sel_o | output | 10 | Five 2-bit shape selectors |
| en_o | output | 5 | Five operand enable bits |
| persist_o | output | 1 | Persistence flag |

## Verification
Broadcast masks with two bits (adjacent, and the two end operands), one bit, no bits and all five bits are applied. Together they separate rising-order allocation from any other order, show the modulo-4 wrap that puts A and D1 on shape 0, and fix latency at popcount plus one. Targeted commands follow a broadcast and use a destination operand, the highest shape and an invalid operand code. They show that untouched shapes and bindings survive and that codes above 4 only write the shape. Extreme field values (register 31, count code 31, skip and 1D set) expose field placement and dimension carry. A second start during a five-bit sequence shows it is dropped.

// File: rtl/remap_index_seq.sv
module remap_index_seq #(
  parameter int OPS    = 5,
  parameter int SHAPES = 4,
  parameter int SW     = 18
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  mm_i,
  input  logic [4:0]            rmm_i,
  input  logic [4:0]            rs_i,
  input  logic [4:0]            svd_i,
  input  logic [1:0]            ew_i,
  input  logic                  yx_i,
  input  logic                  sk_i,
  input  logic                  pst_set_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [SHAPES*SW-1:0]  shapes_o,
  output logic [OPS*2-1:0]      sel_o,
  output logic [OPS-1:0]        en_o,
  output logic                  persist_o
);
  logic [SW-1:0]  shape_q [SHAPES];
  logic [1:0]     sel_q   [OPS];
  logic [OPS-1:0] en_q, pend_q, low_oh;
  logic [SW-1:0]  cfg_q, cfg_d;
  logic [1:0]     idx_q;
  logic [2:0]     low_idx;
  logic           busy_q, done_q, pst_q, last;

  assign cfg_d  = {~yx_i, sk_i, yx_i, ew_i, 6'({1'b0, svd_i}) + 6'd1, {rs_i, 2'b00}};
  assign low_oh = pend_q & (~pend_q + OPS'(1));
  assign last   = (pend_q & ~low_oh) == '0;

  always_comb begin
    low_idx = '0;
    for (int k = OPS - 1; k >= 0; k--)
      if (pend_q[k]) low_idx = 3'(k);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SHAPES; s++) shape_q[s] <= '0;
      for (int k = 0; k < OPS; k++) sel_q[k] <= '0;
      en_q <= '0; pend_q <= '0; cfg_q <= '0; idx_q <= '0;
      busy_q <= 1'b0; done_q <= 1'b0; pst_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (pst_set_i) pst_q <= 1'b1;
      if (start_i && !busy_q) begin
        if (!mm_i) begin
          for (int s = 0; s < SHAPES; s++) shape_q[s] <= '0;
          for (int k = 0; k < OPS; k++) sel_q[k] <= '0;
          en_q   <= '0;
          pst_q  <= 1'b0;
          pend_q <= rmm_i;
          idx_q  <= '0;
          cfg_q  <= cfg_d;
          busy_q <= |rmm_i;
          done_q <= ~|rmm_i;
        end else begin
          shape_q[rmm_i[4:3]] <= cfg_d;
          if (rmm_i[2:0] < 3'(OPS)) begin
            en_q[rmm_i[2:0]]  <= 1'b1;
            sel_q[rmm_i[2:0]] <= rmm_i[4:3];
          end
          done_q <= 1'b1;
        end
      end else if (busy_q) begin
        shape_q[idx_q] <= cfg_q;
        en_q[low_idx]  <= 1'b1;
        sel_q[low_idx] <= idx_q;
        idx_q          <= idx_q + 2'd1;
        pend_q         <= pend_q & ~low_oh;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  for (genvar s = 0; s < SHAPES; s++) begin : g_shp
    assign shapes_o[s*SW +: SW] = shape_q[s];
  end
  for (genvar k = 0; k < OPS; k++) begin : g_sel
    assign sel_o[k*2 +: 2] = sel_q[k];
  end

  assign en_o      = en_q;
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign persist_o = pst_q;
endmodule

// File: rtl/remap_index_seq_chk.sv
module remap_index_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        mm_i,
  input logic        pst_set_i,
  input logic        busy_o,
  input logic        done_o,
  input logic [71:0] shapes_o,
  input logic [4:0]  en_o,
  input logic        persist_o
);
  assert_bcast_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o && !mm_i |=> en_o == 5'd0 && !persist_o);

  assert_one_bind_per_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $countones(en_o) == $countones($past(en_o)) + 1);

  assert_bind_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (en_o & $past(en_o)) == $past(en_o));

  assert_targeted_keeps_pst_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o && mm_i && !pst_set_i |=> persist_o == $past(persist_o));

  assert_targeted_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o && mm_i |=> done_o && !busy_o);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> !done_o);

  assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i && $countones(en_o) < 4 |=> busy_o);

  assert_pst_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pst_set_i && !(start_i && !busy_o && !mm_i) |=> persist_o);

  for (genvar s = 0; s < 4; s++) begin : g_oned
    assert_oned_mark_R8: assert property (@(posedge clk) disable iff (!rst_n)
      shapes_o[s*18 +: 18] != 18'd0 |-> shapes_o[s*18+17] != shapes_o[s*18+15]);
  end
endmodule

bind remap_index_seq remap_index_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .mm_i(mm_i), .pst_set_i(pst_set_i),
  .busy_o(busy_o), .done_o(done_o), .shapes_o(shapes_o), .en_o(en_o),
  .persist_o(persist_o)
);

// File: tb/test_remap_index_seq.sv
module test_remap_index_seq;
  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, mm_i = 1'b0;
  logic [4:0] rmm_i = '0, rs_i = '0, svd_i = '0;
  logic [1:0] ew_i = '0;
  logic yx_i = 1'b0, sk_i = 1'b0, pst_set_i = 1'b0;
  logic busy_o, done_o, persist_o;
  logic [71:0] shapes_o;
  logic [9:0] sel_o;
  logic [4:0] en_o;

  always #10 clk = ~clk;

  remap_index_seq i_remap_index_seq (.*);

  typedef struct packed {
    logic [7:0]  lat;
    logic        pst;
    logic [4:0]  en;
    logic [9:0]  sel;
    logic [71:0] shp;
  } exp_t;

  exp_t  q[$];
  string tq[$];
  int checks = 0, fails = 0;
  int cnt = 0, t0 = 0;
  logic [17:0] m_sh [4];
  logic [1:0]  m_sel [5];
  logic [4:0]  m_en;
  logic        m_pst;

  always @(posedge clk) cnt <= cnt + 1;

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && done_o) begin
    if (q.size() == 0) chk("R9 unexpected done", 1, 0);
    else begin
      exp_t e;
      string t;
      e = q.pop_front();
      t = tq.pop_front();
      chk({t, " latency R9"}, 128'(cnt - t0), 128'(e.lat));
      chk({t, " enables"}, 128'(en_o), 128'(e.en));
      chk({t, " selectors"}, 128'(sel_o), 128'(e.sel));
      chk({t, " shapes R7"}, 128'(shapes_o), 128'(e.shp));
      chk({t, " persistence"}, 128'(persist_o), 128'(e.pst));
    end
  end

  task automatic cmd(string tag, logic mm, logic [4:0] rmm, logic [4:0] rs,
                     logic [4:0] svd, logic [1:0] ew, logic yx, logic sk, bit spoil);
    exp_t e;
    logic [17:0] cfg;
    int idx = 0, n = 0;
    cfg = {~yx, sk, yx, ew, 6'(svd) + 6'd1, rs, 2'b00};
    if (!mm) begin
      for (int s = 0; s < 4; s++) m_sh[s] = '0;
      for (int k = 0; k < 5; k++) m_sel[k] = '0;
      m_en = '0; m_pst = 1'b0;
      for (int k = 0; k < 5; k++) if (rmm[k]) begin
        m_sh[idx] = cfg; m_sel[k] = 2'(idx); m_en[k] = 1'b1;
        idx = (idx + 1) % 4; n++;
      end
    end else begin
      m_sh[rmm[4:3]] = cfg;
      if (rmm[2:0] < 5) begin m_en[rmm[2:0]] = 1'b1; m_sel[rmm[2:0]] = rmm[4:3]; end
    end
    e.lat = mm ? 8'd1 : 8'(n + 1);
    e.pst = m_pst; e.en = m_en;
    for (int k = 0; k < 5; k++) e.sel[k*2 +: 2] = m_sel[k];
    for (int s = 0; s < 4; s++) e.shp[s*18 +: 18] = m_sh[s];
    q.push_back(e); tq.push_back(tag);
    @(negedge clk);
    mm_i = mm; rmm_i = rmm; rs_i = rs; svd_i = svd; ew_i = ew; yx_i = yx; sk_i = sk;
    start_i = 1'b1; t0 = cnt;
    @(negedge clk); start_i = 1'b0;
    if (spoil) begin
      mm_i = 1'b1; rmm_i = 5'b11001; rs_i = 5'd9; svd_i = 5'd2; start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
    end
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    for (int s = 0; s < 4; s++) m_sh[s] = '0;
    for (int k = 0; k < 5; k++) m_sel[k] = '0;
    m_en = '0; m_pst = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset outputs", {shapes_o, sel_o, en_o, persist_o, busy_o, done_o}, '0);
    cmd("R3 mask 00110", 1'b0, 5'b00110, 5'd3, 5'd7, 2'd1, 1'b1, 1'b0, 1'b0);
    cmd("R4 mask 11111", 1'b0, 5'b11111, 5'd5, 5'd0, 2'd2, 1'b0, 1'b0, 1'b0);
    cmd("R8 extremes", 1'b0, 5'b00011, 5'd31, 5'd31, 2'd3, 1'b0, 1'b1, 1'b0);
    @(negedge clk); pst_set_i = 1'b1;
    @(negedge clk); pst_set_i = 1'b0; m_pst = 1'b1;
    chk("R11 persistence set", 128'(persist_o), 1);
    cmd("R6 targeted 10011", 1'b1, 5'b10011, 5'd2, 5'd3, 2'd0, 1'b1, 1'b1, 1'b0);
    cmd("R5 targeted 11100", 1'b1, 5'b11100, 5'd7, 5'd15, 2'd1, 1'b0, 1'b0, 1'b0);
    cmd("R5 bad operand", 1'b1, 5'b01110, 5'd4, 5'd1, 2'd2, 1'b1, 1'b0, 1'b0);
    cmd("R2 mask 10001", 1'b0, 5'b10001, 5'd1, 5'd4, 2'd0, 1'b1, 1'b0, 1'b0);
    cmd("R9 empty mask", 1'b0, 5'b00000, 5'd6, 5'd6, 2'd1, 1'b1, 1'b1, 1'b0);
    cmd("R10 start while busy", 1'b0, 5'b11111, 5'd12, 5'd9, 2'd3, 1'b1, 1'b0, 1'b1);
    cmd("R3 single bit", 1'b0, 5'b01000, 5'd20, 5'd10, 2'd0, 1'b0, 1'b1, 1'b0);
    report();
  end
endmodule